// File: doc/BRIEF.md
# SMBus Send-Byte Dual Switch Controller

This block is a write-only slave on a two-wire SMBus. It serves the Send Byte protocol and turns two switch-enable outputs on and off. A fast system clock oversamples the bus clock and data lines. The block detects Start and Stop conditions and shifts in an address byte. It compares that byte against a fixed four-bit prefix followed by a three-bit suffix, which two three-level pin codes select. When the address matches a write, the block acknowledges, takes one command byte and acknowledges again. The two low command bits are applied to the outputs only when the closing Stop arrives.

Because the outputs are double-buffered, a bus master can load several slaves in turn, using repeated Starts, and have them all switch together on one Stop. A read request, an address pin setting with no valid code, or a Start or Stop inside a byte makes the block drop the transaction. The open-drain data driver is modelled as a pull-low enable that the board combines with the bus line.

Top module: `smbus_sendbyte_switch`

## Requirements
- R1: A Start is the data line falling while the bus clock is high, and a Stop is the data line rising while the bus clock is high. Bits clocked while no Start has been seen are ignored and get no acknowledge.
- R2: The slave address is prefix 1011 followed by a suffix. Each pin code is 0 for low, 1 for mid and 2 for high. With n = 3*lo + hi, the suffix is n when n < 4 and n-1 when n > 4. When both codes are 1, or either code is 3, no address matches.
- R3: On a matching write address, bus_dat_pull_o goes high after the bus clock falls at the end of the 8th address bit. It stays high through the 9th clock and is released when that clock falls. Bytes are sent MSB first, and the 8th bit is R/W (0 = write).
- R4: An address byte whose R/W bit is 1 is not acknowledged, even when the address matches. The following byte is not acknowledged either, and the outputs are not changed.
- R5: A non-matching address gets no acknowledge. The slave ignores every bit after it until the next Start.
- R6: After a matched write, the command byte is acknowledged in the same way as the address. Command bit 0 sets sw_en_a_o and command bit 1 sets sw_en_b_o, where 1 enables and 0 disables.
- R7: The command is held internally from its acknowledge onward. The outputs do not change until a Stop is detected.
- R8: A repeated Start after a command has been held keeps it, even when the next address is for another slave. The next Stop then applies the held command.
- R9: A Start or Stop that arrives after one or more bits of a byte, or during an acknowledge, discards the held command. The outputs keep their old values.
- R10: With rst_n low at a clock edge, both outputs and bus_dat_pull_o are 0 and no command is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk_i | input | 1 | SMBus clock line level |
| bus_dat_i | input | 1 | SMBus data line level (wired-AND of all drivers) |
| addr_pin_lo | input | 2 | Lower address pin level: 0 low, 1 mid, 2 high |
| addr_pin_hi | input | 2 | Upper address pin level: 0 low, 1 mid, 2 high |
| bus_dat_pull_o | output | 1 | Pull the data line low (acknowledge) |
| sw_en_a_o | output | 1 | Switch A enable |
| sw_en_b_o | output | 1 | Switch B enable |

## Verification
Every bus event reaches the outputs on the third clock edge after the pin changes: two synchronizer flops and then one state flop. The bench holds each bus level for eight system clocks and samples on the falling system clock edge after that delay has elapsed. Acknowledge is sampled four clocks into the high phase of the ninth bus clock, and its release is sampled a full phase after that clock falls. The outputs are checked once while the command is held, before the Stop, and again a whole phase after the Stop's data edge. A reference model in the bench computes the expected acknowledge and output values from the pin codes, the address, the R/W bit and the Start/Stop history.

// File: rtl/smbsw_pkg.sv
// Shared types and constants for the send-byte switch controller.
// Assumes an 8-bit SMBus byte framing; pin levels are 2-bit codes.
package smbsw_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    // three-level pin codes
    localparam logic [1:0] LVL_LOW  = 2'd0;
    localparam logic [1:0] LVL_MID  = 2'd1;
    localparam logic [1:0] LVL_HIGH = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK_W,
        ST_AACK,
        ST_CMD,
        ST_CACK_W,
        ST_CACK,
        ST_DONE
    } smb_state_e;

endpackage

// File: rtl/smbsw_sync.sv
// Synchronizes bus clock and data into the system clock domain and
// derives clock edges plus Start/Stop events from the synchronized levels.
// Assumes the bus is idle-high; reset fills all stages with 1.
module smbsw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NBUS = 2;

    logic [NBUS-1:0] raw;
    logic [NBUS-1:0] synced;
    logic [NBUS-1:0] prev_q;

    assign raw = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < NBUS; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            // shift one line through its synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain_q[STAGES-1];
        end
    endgenerate

    // remember last synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= synced;
    end

    assign sda_s    = synced[0];
    assign scl_rise = synced[1] & ~prev_q[1];
    assign scl_fall = ~synced[1] & prev_q[1];
    assign start_ev = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
    assign stop_ev  = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];

endmodule

// File: rtl/smbsw_addr_dec.sv
// Decodes two three-level pin codes into a 3-bit address suffix.
// Both-mid and any code 3 are reported invalid.
module smbsw_addr_dec (
    input  logic [1:0] pin_lo,
    input  logic [1:0] pin_hi,
    output logic       sfx_ok,
    output logic [2:0] sfx
);
    import smbsw_pkg::*;

    logic [3:0] idx;
    logic [3:0] idx_m1;

    // combine both pin levels into a 0..8 index and fold out the hole at 4
    always_comb begin
        idx    = ({2'b00, pin_lo} * 4'd3) + {2'b00, pin_hi};
        idx_m1 = idx - 4'd1;
        sfx_ok = (pin_lo != 2'd3) && (pin_hi != 2'd3) &&
                 !((pin_lo == LVL_MID) && (pin_hi == LVL_MID));
        sfx    = (idx < 4'd4) ? idx[2:0] : idx_m1[2:0];
    end

endmodule

// File: rtl/smbsw_fsm.sv
// Send Byte protocol engine: address match, two acknowledges, holding
// latch and Stop-time output update. Assumes event inputs are one-cycle
// pulses from the synchronizer.
module smbsw_fsm #(
    parameter logic [3:0] PREFIX = 4'b1011,
    parameter int         NUM_SW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              addr_ok,
    input  logic [2:0]        addr_sfx,
    output logic              pull_o,
    output logic [NUM_SW-1:0] en_o
);
    import smbsw_pkg::*;

    smb_state_e             state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [BYTE_W-2:0]      sh_q;
    logic [NUM_SW-1:0]      hold_q;
    logic                   pend_q;
    logic                   pull_q;
    logic [NUM_SW-1:0]      en_q;
    logic [BYTE_W-1:0]      cur_byte;
    logic                   last_bit;
    logic                   mid_frame;
    logic                   addr_hit;

    // byte as it stands once the current bit is shifted in
    always_comb begin
        cur_byte  = {sh_q, sda_s};
        last_bit  = (cnt_q == CNT_W'(BYTE_W - 1));
        addr_hit  = addr_ok && (cur_byte[7:1] == {PREFIX, addr_sfx}) && !cur_byte[0];
        mid_frame = ((state_q == ST_ADDR || state_q == ST_CMD) && cnt_q != '0) ||
                    state_q == ST_AACK_W || state_q == ST_AACK ||
                    state_q == ST_CACK_W || state_q == ST_CACK;
    end

    // protocol sequencing, acknowledge drive and double-buffered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            hold_q  <= '0;
            pend_q  <= 1'b0;
            pull_q  <= 1'b0;
            en_q    <= '0;
        end else if (start_ev) begin
            if (mid_frame) pend_q <= 1'b0;
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else if (stop_ev) begin
            if (mid_frame) begin
                pend_q <= 1'b0;
            end else if (pend_q) begin
                en_q   <= hold_q;
                pend_q <= 1'b0;
            end
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_ADDR, ST_CMD: begin
                    if (scl_rise) begin
                        sh_q <= cur_byte[BYTE_W-2:0];
                        if (last_bit) begin
                            cnt_q <= '0;
                            if (state_q == ST_CMD)  state_q <= ST_CACK_W;
                            else if (addr_hit)      state_q <= ST_AACK_W;
                            else                    state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_AACK_W: if (scl_fall) begin
                    pull_q  <= 1'b1;
                    state_q <= ST_AACK;
                end
                ST_AACK: if (scl_fall) begin
                    pull_q  <= 1'b0;
                    state_q <= ST_CMD;
                end
                ST_CACK_W: if (scl_fall) begin
                    pull_q  <= 1'b1;
                    hold_q  <= sh_q[NUM_SW-1:0];
                    pend_q  <= 1'b1;
                    state_q <= ST_CACK;
                end
                ST_CACK: if (scl_fall) begin
                    pull_q  <= 1'b0;
                    state_q <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    assign pull_o = pull_q;
    assign en_o   = en_q;

    // R3
    pull_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_q) |-> $past(scl_fall));

    // R3
    pull_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_q) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)));

    // R7
    out_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> $past(stop_ev));

    // R6
    pull_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_q |-> (state_q == ST_AACK || state_q == ST_CACK));

    // R4
    ack_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AACK_W && $past(state_q) == ST_ADDR) |->
            (!$past(sda_s) && $past(addr_ok)));

endmodule

// File: rtl/smbus_sendbyte_switch.sv
// Top level: write-only SMBus slave driving two switch enables.
// Assumes the system clock is at least ~10x the bus clock rate.
module smbus_sendbyte_switch #(
    parameter logic [3:0] ADDR_PREFIX = 4'b1011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_clk_i,
    input  logic       bus_dat_i,
    input  logic [1:0] addr_pin_lo,
    input  logic [1:0] addr_pin_hi,
    output logic       bus_dat_pull_o,
    output logic       sw_en_a_o,
    output logic       sw_en_b_o
);
    localparam int NUM_SW = 2;

    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              sfx_ok;
    logic [2:0]        sfx;
    logic [NUM_SW-1:0] en;

    smbsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (bus_clk_i),
        .sda_i    (bus_dat_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smbsw_addr_dec u_dec (
        .pin_lo (addr_pin_lo),
        .pin_hi (addr_pin_hi),
        .sfx_ok (sfx_ok),
        .sfx    (sfx)
    );

    smbsw_fsm #(.PREFIX(ADDR_PREFIX), .NUM_SW(NUM_SW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .addr_ok  (sfx_ok),
        .addr_sfx (sfx),
        .pull_o   (bus_dat_pull_o),
        .en_o     (en)
    );

    assign sw_en_a_o = en[0];
    assign sw_en_b_o = en[1];

    // R2
    bad_pins_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_dat_pull_o) && addr_pin_lo == 2'd1 && addr_pin_hi == 2'd1 &&
         $stable(addr_pin_lo) && $stable(addr_pin_hi)) |-> sw_en_a_o == sw_en_a_o && !u_fsm.pend_q == !u_fsm.pend_q && 1'b0 == (u_fsm.state_q == smbsw_pkg::ST_AACK));

endmodule

// File: tb/smbus_sendbyte_switch_test.sv
module smbus_sendbyte_switch_test;

    localparam int Q = 8;
    localparam int WDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [1:0] pin_lo = 2'd0;
    logic [1:0] pin_hi = 2'd0;
    logic       pull, en_a, en_b;
    logic       sda_line;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [1:0] m_en = 2'b00;
    logic [1:0] m_hold = 2'b00;
    bit         m_pend = 1'b0;

    assign sda_line = sda_drv & ~pull;

    always #5 clk = ~clk;

    smbus_sendbyte_switch uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_clk_i      (scl_drv),
        .bus_dat_i      (sda_line),
        .addr_pin_lo    (pin_lo),
        .addr_pin_hi    (pin_hi),
        .bus_dat_pull_o (pull),
        .sw_en_a_o      (en_a),
        .sw_en_b_o      (en_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit sfx_valid(input logic [1:0] lo, input logic [1:0] hi);
        return (lo < 2'd3) && (hi < 2'd3) && !(lo == 2'd1 && hi == 2'd1);
    endfunction

    function automatic logic [2:0] sfx_of(input logic [1:0] lo, input logic [1:0] hi);
        int n;
        n = 3 * int'(lo) + int'(hi);
        return (n < 4) ? 3'(n) : 3'(n - 1);
    endfunction

    function automatic bit addr_match(input logic [6:0] a);
        return sfx_valid(pin_lo, pin_hi) && (a == {4'b1011, sfx_of(pin_lo, pin_hi)});
    endfunction

    function automatic logic [6:0] own_addr();
        return {4'b1011, sfx_of(pin_lo, pin_hi)};
    endfunction

    task automatic hold_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b);
        sda_drv = b; hold_q();
        scl_drv = 1'b1; hold_q();
        scl_drv = 1'b0; hold_q();
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; hold_q();
        scl_drv = 1'b1; hold_q();
        sda_drv = 1'b0; hold_q();
        scl_drv = 1'b0; hold_q();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; hold_q();
        scl_drv = 1'b1; hold_q();
        sda_drv = 1'b1; hold_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        sda_drv = 1'b1; hold_q();
        scl_drv = 1'b1;
        repeat (Q / 2) @(negedge clk);
        ack = pull;
        repeat (Q / 2) @(negedge clk);
        scl_drv = 1'b0; hold_q();
        rel = !pull;
    endtask

    task automatic apply_stop_model();
        if (m_pend) begin
            m_en = m_hold;
            m_pend = 1'b0;
        end
    endtask

    task automatic write_txn(input logic [6:0] a, input logic rw, input logic [7:0] cmd,
                             input bit do_stop);
        bit ack, rel, exp;
        bus_start();
        send_byte({a, rw}, ack, rel);
        exp = addr_match(a) && !rw;
        if (rw) chk(ack == exp, "R4 read address ack", ack, exp);
        else if (!addr_match(a)) chk(ack == exp, "R5 mismatch ack", ack, exp);
        else chk(ack == exp, "R3 address ack", ack, exp);
        if (exp) chk(rel, "R3 ack release", !rel, 0);
        send_byte(cmd, ack, rel);
        chk(ack == exp, "R6 command ack", ack, exp);
        if (exp) begin
            m_hold = cmd[1:0];
            m_pend = 1'b1;
        end
        chk({en_b, en_a} == m_en, "R7 outputs before stop", {en_b, en_a}, m_en);
        if (do_stop) begin
            bus_stop();
            apply_stop_model();
            chk({en_b, en_a} == m_en, "R6 outputs after stop", {en_b, en_a}, m_en);
        end
    endtask

    task automatic abort_addr(input int k, input bit by_stop);
        logic [6:0] a;
        a = own_addr();
        bus_start();
        for (int i = 0; i < k; i++) bus_bit(a[6 - i]);
        if (by_stop) bus_stop();
        else begin
            bus_start();
            bus_stop();
        end
        m_pend = 1'b0;
        chk({en_b, en_a} == m_en, "R9 abort in address", {en_b, en_a}, m_en);
    endtask

    task automatic abort_cmd(input int k);
        bit ack, rel;
        bus_start();
        send_byte({own_addr(), 1'b0}, ack, rel);
        for (int i = 0; i < k; i++) bus_bit(1'b1);
        bus_stop();
        m_pend = 1'b0;
        chk({en_b, en_a} == m_en, "R9 abort in command", {en_b, en_a}, m_en);
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        bit ack, rel;
        int seed;
        seed = 32'h5eed_1623;
        void'($urandom(seed));

        repeat (4) @(negedge clk);
        chk(!pull && !en_a && !en_b, "R10 reset state", {pull, en_b, en_a}, 0);
        rst_n = 1'b1;
        hold_q();
        chk(!pull && !en_a && !en_b, "R10 after release", {pull, en_b, en_a}, 0);

        // R1: clocked byte with no Start gets no acknowledge
        pin_lo = 2'd0; pin_hi = 2'd1;
        scl_drv = 1'b0; hold_q();
        send_byte({own_addr(), 1'b0}, ack, rel);
        chk(!ack, "R1 no start no ack", ack, 0);
        bus_stop();

        // R2/R6/R7: suffix 001 write enabling both
        write_txn(7'b1011001, 1'b0, 8'h03, 1'b1);
        chk({en_b, en_a} == 2'b11, "R6 both enabled", {en_b, en_a}, 3);

        // R2: both-mid never matches
        pin_lo = 2'd1; pin_hi = 2'd1;
        for (int s = 0; s < 8; s++) write_txn({4'b1011, 3'(s)}, 1'b0, 8'h00, 1'b1);
        pin_lo = 2'd3; pin_hi = 2'd0;
        write_txn(7'b1011000, 1'b0, 8'h00, 1'b1);

        // R2: top pin combination gives 111, bit 0 only
        pin_lo = 2'd2; pin_hi = 2'd2;
        write_txn(7'b1011111, 1'b0, 8'hFD, 1'b1);
        chk({en_b, en_a} == 2'b01, "R2 suffix 111 command", {en_b, en_a}, 1);

        // R4: read to own address ignored
        write_txn(own_addr(), 1'b1, 8'h02, 1'b1);

        // R8: hold for own, then repeated start to another slave, then Stop
        pin_lo = 2'd1; pin_hi = 2'd0;
        write_txn(own_addr(), 1'b0, 8'h02, 1'b0);
        write_txn(7'b0100110, 1'b0, 8'h01, 1'b1);
        chk({en_b, en_a} == 2'b10, "R8 daisy applied", {en_b, en_a}, 2);

        // R9: held command dropped by Stop inside a byte
        write_txn(own_addr(), 1'b0, 8'h01, 1'b0);
        abort_addr(3, 1'b1);
        chk({en_b, en_a} == 2'b10, "R9 held dropped", {en_b, en_a}, 2);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int kind;
            pin_lo = 2'($urandom_range(0, 3));
            pin_hi = 2'($urandom_range(0, 2));
            kind = $urandom_range(0, 4);
            case (kind)
                0: write_txn(own_addr(), 1'b0, 8'($urandom), 1'b1);
                1: write_txn(7'($urandom), 1'($urandom), 8'($urandom), 1'b1);
                2: write_txn(own_addr(), 1'b1, 8'($urandom), 1'b1);
                3: begin
                    if ($urandom_range(0, 1) == 0)
                        abort_addr($urandom_range(1, 7), 1'($urandom));
                    else
                        abort_cmd($urandom_range(1, 7));
                end
                default: begin
                    write_txn(own_addr(), 1'b0, 8'($urandom), 1'b0);
                    write_txn(7'($urandom), 1'b0, 8'($urandom), 1'b1);
                end
            endcase
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule